// File: doc/BRIEF.md
# Mode-Select Clock Divider With Strap Pin

This block sits between a clock synthesiser and the output pins of a clock generator. A 2-bit function select picks one of four behaviours for every output group (CPU, SDRAM, 66 MHz fixed, PCI, APIC, 48 MHz and reference). In the first, every group is released to high impedance. In the second, every group is a fixed division of a test clock. The third and fourth are normal modes that route synthesiser clocks, and they differ only in the CPU group, which takes either the 66 MHz or the 100 MHz source. All test-mode ratios come from one shared phase counter, so their rising edges line up on a common test-clock edge.

The reference output shares its pin with a configuration strap. After reset the pin is an input. A parameterised counter counts a free-running tick, and while it runs the pin's driver stays off. The pin level on the final tick is captured as the APIC divide strap, and from the next cycle the pin drives the reference clock. A low strap makes the APIC group run at half the PCI rate. A high strap makes it run at the PCI rate. In both cases the APIC edges coincide with PCI rising edges.

Top module: `clk_mode_divider`

## Requirements
- R1: With select 2'b00, every output enable is 0 and every clock output is 0.
- R2: With select 2'b01, the CPU, SDRAM and 48 MHz outputs are the test clock divided by 2 at 50% duty, high in the first cycle after entry into the mode.
- R3: With select 2'b01, the 66 MHz fixed output is the test clock divided by 3: high for 1 cycle, then low for 2.
- R4: With select 2'b01, the PCI output is the test clock divided by 6 at 50% duty, and the reference output equals the test clock itself.
- R5: With select 2'b10 the CPU output copies the 66 MHz source, and with 2'b11 it copies the 100 MHz source. In both modes SDRAM copies the 100 MHz source, the 66 MHz fixed group copies the 66 MHz source, PCI copies the 33 MHz source, the 48 MHz group copies the 48 MHz source and the reference output copies the oscillator.
- R6: After reset the reference enable and the reference output stay 0 until PWRON_TICKS tick pulses have been counted. The enable is 1 from the cycle after the final tick, in every select code other than 2'b00, and it stays 1 until the next reset.
- R7: The strap is the reference pin level in the cycle of the final tick. It holds until reset, and later pin changes do not affect it. Before capture the strap reads as high.
- R8: With a high strap, the APIC output equals PCI (divide by 6 in test mode, a copy of the 33 MHz source otherwise). With a low strap, the APIC output is the test clock divided by 12 in test mode. In normal modes it is high from one 33 MHz rising edge to the next, and low until the rising edge after that.
- R9: The test dividers are held at phase 0 outside test mode, so on entry the divide-by-2, -3, -6 and -12 outputs all rise in the same cycle.
- R10: A synchronous active-high reset clears the tick count, the completion flag and the divider phase, and sets the strap high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; clocks all internal state |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 2 | Function select code |
| tick_i | input | 1 | Free-running reference tick for the power-on window |
| ref_pad_i | input | 1 | Level seen on the shared reference/strap pin |
| pll_66_i | input | 1 | 66 MHz synthesiser clock |
| pll_100_i | input | 1 | 100 MHz synthesiser clock |
| pll_33_i | input | 1 | 33 MHz synthesiser clock |
| pll_48_i | input | 1 | 48 MHz synthesiser clock |
| osc_i | input | 1 | Crystal oscillator reference |
| cpu_o | output | 1 | CPU group clock |
| cpu_oe | output | 1 | CPU group driver enable |
| sdram_o | output | 1 | SDRAM group clock |
| sdram_oe | output | 1 | SDRAM group driver enable |
| v66_o | output | 1 | 66 MHz fixed group clock |
| v66_oe | output | 1 | 66 MHz fixed group driver enable |
| pci_o | output | 1 | PCI group clock |
| pci_oe | output | 1 | PCI group driver enable |
| apic_o | output | 1 | APIC group clock |
| apic_oe | output | 1 | APIC group driver enable |
| usb_o | output | 1 | 48 MHz group clock |
| usb_oe | output | 1 | 48 MHz group driver enable |
| ref_o | output | 1 | Reference clock driven onto the shared pin |
| ref_oe | output | 1 | Shared pin driver enable |

## Verification
The bench builds the block with PWRON_TICKS set to 4. With that value a complete power-on window fits into a few cycles, so the bench can move the pin level just before the final tick and show that only the captured level counts. The short window also leaves room for two full 12-cycle test-divider periods under each strap value. It also allows the half-rate APIC pattern to be checked against a bench-side count of 33 MHz rising edges.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

    typedef enum logic [1:0] {
        MODE_HIZ  = 2'b00,
        MODE_TEST = 2'b01,
        MODE_N66  = 2'b10,
        MODE_N100 = 2'b11
    } clk_mode_e;

    // One bit per output group
    typedef struct packed {
        logic cpu;
        logic sdram;
        logic v66;
        logic pci;
        logic apic;
        logic usb;
        logic refc;
    } clk_grp_t;

    // Test-mode divided clocks
    typedef struct packed {
        logic d2;
        logic d3;
        logic d6;
        logic d12;
    } tdiv_t;

    // Shared phase counter wraps at the least common multiple of all ratios
    localparam int unsigned DIV_CYCLE = 12;

    // High while the phase lies in the first high_len cycles of each period
    function automatic logic phase_high(input int unsigned phase,
                                        input int unsigned period,
                                        input int unsigned high_len);
        return (phase % period) < high_len;
    endfunction

    function automatic clk_grp_t grp_enable(input clk_mode_e m, input logic done);
        clk_grp_t g;
        if (m == MODE_HIZ) begin
            g = '0;
        end else begin
            g      = '1;
            g.refc = done;
        end
        return g;
    endfunction

endpackage

// File: rtl/clk_pwron_strap.sv
module clk_pwron_strap #(
    parameter int unsigned PWRON_TICKS = 28636
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic pad_i,
    output logic done_o,
    output logic strap_o
);
    localparam int unsigned CW = $clog2(PWRON_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(PWRON_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic          strap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            done_q  <= 1'b0;
            strap_q <= 1'b1;
        end else if (!done_q && tick_i) begin
            if (cnt_q == LAST) begin
                done_q  <= 1'b1;
                strap_q <= pad_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done_o  = done_q;
    assign strap_o = strap_q;
endmodule

// File: rtl/clk_test_divider.sv
module clk_test_divider
    import clk_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run_i,
    output tdiv_t div_o
);
    localparam int unsigned CNT_W = $clog2(DIV_CYCLE);
    localparam logic [CNT_W-1:0] WRAP = CNT_W'(DIV_CYCLE - 1);

    logic [CNT_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            phase_q <= '0;
        end else if (phase_q == WRAP) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    always_comb begin
        div_o.d2  = phase_high(int'(phase_q), 2, 1);
        div_o.d3  = phase_high(int'(phase_q), 3, 1);
        div_o.d6  = phase_high(int'(phase_q), 6, 3);
        div_o.d12 = phase_high(int'(phase_q), 12, 6);
    end
endmodule

// File: rtl/clk_apic_halver.sv
module clk_apic_halver (
    input  logic clk,
    input  logic rst,
    input  logic pci_i,
    output logic half_o
);
    logic prev_q;
    logic ph_q;
    logic rise;

    assign rise   = pci_i & ~prev_q;
    // Flip in the same cycle as the PCI rising edge so the edges coincide
    assign half_o = rise ? ~ph_q : ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            ph_q   <= 1'b0;
        end else begin
            prev_q <= pci_i;
            if (rise) ph_q <= ~ph_q;
        end
    end
endmodule

// File: rtl/clk_mode_divider.sv
module clk_mode_divider
    import clk_mode_pkg::*;
#(
    parameter int unsigned PWRON_TICKS = 28636
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel_i,
    input  logic       tick_i,
    input  logic       ref_pad_i,
    input  logic       pll_66_i,
    input  logic       pll_100_i,
    input  logic       pll_33_i,
    input  logic       pll_48_i,
    input  logic       osc_i,
    output logic       cpu_o,
    output logic       cpu_oe,
    output logic       sdram_o,
    output logic       sdram_oe,
    output logic       v66_o,
    output logic       v66_oe,
    output logic       pci_o,
    output logic       pci_oe,
    output logic       apic_o,
    output logic       apic_oe,
    output logic       usb_o,
    output logic       usb_oe,
    output logic       ref_o,
    output logic       ref_oe
);
    clk_mode_e mode;
    logic      pwr_done;
    logic      strap_lvl;
    logic      apic_half;
    tdiv_t     tdiv;
    clk_grp_t  src;
    clk_grp_t  oe;
    clk_grp_t  dat;

    assign mode = clk_mode_e'(sel_i);

    clk_pwron_strap #(.PWRON_TICKS(PWRON_TICKS)) u_pwron (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .pad_i   (ref_pad_i),
        .done_o  (pwr_done),
        .strap_o (strap_lvl)
    );

    clk_test_divider u_tdiv (
        .clk   (clk),
        .rst   (rst),
        .run_i (mode == MODE_TEST),
        .div_o (tdiv)
    );

    clk_apic_halver u_half (
        .clk    (clk),
        .rst    (rst),
        .pci_i  (pll_33_i),
        .half_o (apic_half)
    );

    always_comb begin
        src = '0;
        unique case (mode)
            MODE_HIZ: src = '0;
            MODE_TEST: begin
                src.cpu   = tdiv.d2;
                src.sdram = tdiv.d2;
                src.usb   = tdiv.d2;
                src.v66   = tdiv.d3;
                src.pci   = tdiv.d6;
                src.apic  = strap_lvl ? tdiv.d6 : tdiv.d12;
                src.refc  = clk;
            end
            MODE_N66, MODE_N100: begin
                src.cpu   = (mode == MODE_N100) ? pll_100_i : pll_66_i;
                src.sdram = pll_100_i;
                src.v66   = pll_66_i;
                src.pci   = pll_33_i;
                src.apic  = strap_lvl ? pll_33_i : apic_half;
                src.usb   = pll_48_i;
                src.refc  = osc_i;
            end
            default: src = '0;
        endcase
    end

    assign oe  = grp_enable(mode, pwr_done);
    assign dat = clk_grp_t'(src & oe);

    assign cpu_o    = dat.cpu;
    assign sdram_o  = dat.sdram;
    assign v66_o    = dat.v66;
    assign pci_o    = dat.pci;
    assign apic_o   = dat.apic;
    assign usb_o    = dat.usb;
    assign ref_o    = dat.refc;
    assign cpu_oe   = oe.cpu;
    assign sdram_oe = oe.sdram;
    assign v66_oe   = oe.v66;
    assign pci_oe   = oe.pci;
    assign apic_oe  = oe.apic;
    assign usb_oe   = oe.usb;
    assign ref_oe   = oe.refc;
endmodule

// File: rtl/clk_mode_divider_chk.sv
module clk_mode_divider_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] sel_i,
    input logic       pwr_done,
    input logic       strap_lvl,
    input logic [6:0] outs,
    input logic [6:0] oes,
    input logic       cpu_o,
    input logic       v66_o,
    input logic       pci_o,
    input logic       apic_o,
    input logic       ref_o,
    input logic       ref_oe
);
    // R1
    p_hiz_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (sel_i == 2'b00) |-> (oes == 7'd0 && outs == 7'd0));

    // R6
    p_ref_off_window_r6: assert property (@(posedge clk) disable iff (rst)
        !pwr_done |-> (!ref_oe && !ref_o));

    // R6
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_done) |-> pwr_done);

    // R7
    p_strap_hold_r7: assert property (@(posedge clk) disable iff (rst)
        $past(pwr_done) |-> $stable(strap_lvl));

    // R9
    p_div_align_r9: assert property (@(posedge clk) disable iff (rst)
        (sel_i == 2'b01 && $past(sel_i) == 2'b01 && $rose(pci_o))
            |-> ($rose(cpu_o) && $rose(v66_o)));

    // R3
    p_v66_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_i == 2'b01 && $past(sel_i) == 2'b01 && $rose(v66_o))
            |=> (!v66_o || sel_i != 2'b01));

    // R8
    p_apic_edge_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_i[1] && $past(sel_i[1]) && pwr_done && $past(pwr_done) && $rose(apic_o))
            |-> $rose(pci_o));
endmodule

bind clk_mode_divider clk_mode_divider_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel_i     (sel_i),
    .pwr_done  (pwr_done),
    .strap_lvl (strap_lvl),
    .outs      ({cpu_o, sdram_o, v66_o, pci_o, apic_o, usb_o, ref_o}),
    .oes       ({cpu_oe, sdram_oe, v66_oe, pci_oe, apic_oe, usb_oe, ref_oe}),
    .cpu_o     (cpu_o),
    .v66_o     (v66_o),
    .pci_o     (pci_o),
    .apic_o    (apic_o),
    .ref_o     (ref_o),
    .ref_oe    (ref_oe)
);

// File: tb/clk_mode_divider_bench.sv
module clk_mode_divider_bench;
    localparam int unsigned TICKS = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] sel = 2'b10;
    logic tick = 1'b0, pad = 1'b1;
    logic p66 = 0, p100 = 0, p33 = 0, p48 = 0, osc = 0;
    logic cpu_o, cpu_oe, sdram_o, sdram_oe, v66_o, v66_oe, pci_o, pci_oe;
    logic apic_o, apic_oe, usb_o, usb_oe, ref_o, ref_oe;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    clk_mode_divider #(.PWRON_TICKS(TICKS)) u_clk_mode_divider (
        .clk(clk), .rst(rst), .sel_i(sel), .tick_i(tick), .ref_pad_i(pad),
        .pll_66_i(p66), .pll_100_i(p100), .pll_33_i(p33), .pll_48_i(p48), .osc_i(osc),
        .cpu_o(cpu_o), .cpu_oe(cpu_oe), .sdram_o(sdram_o), .sdram_oe(sdram_oe),
        .v66_o(v66_o), .v66_oe(v66_oe), .pci_o(pci_o), .pci_oe(pci_oe),
        .apic_o(apic_o), .apic_oe(apic_oe), .usb_o(usb_o), .usb_oe(usb_oe),
        .ref_o(ref_o), .ref_oe(ref_oe)
    );

    // {sel, p66 p100 p33 p48 osc, cpu sdram v66 pci apic usb ref, enables}
    localparam logic [20:0] VEC [8] = '{
        {2'b00, 5'b11111, 7'b0000000, 7'b0000000},
        {2'b10, 5'b10000, 7'b1010000, 7'b1111111},
        {2'b10, 5'b01000, 7'b0100000, 7'b1111111},
        {2'b11, 5'b01000, 7'b1100000, 7'b1111111},
        {2'b11, 5'b10000, 7'b0010000, 7'b1111111},
        {2'b10, 5'b00100, 7'b0001100, 7'b1111111},
        {2'b11, 5'b00011, 7'b0000011, 7'b1111111},
        {2'b00, 5'b00000, 7'b0000000, 7'b0000000}
    };

    function automatic logic [6:0] outs();
        return {cpu_o, sdram_o, v66_o, pci_o, apic_o, usb_o, ref_o};
    endfunction
    function automatic logic [6:0] oes();
        return {cpu_oe, sdram_oe, v66_oe, pci_oe, apic_oe, usb_oe, ref_oe};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // 24 cycles of test mode; strap_hi selects the expected APIC ratio
    task automatic run_test_mode(input logic strap_hi);
        @(negedge clk); sel = 2'b01;
        for (int k = 0; k < 24; k++) begin
            #1;
            chk("R2 cpu /2", cpu_o, (k % 2) == 0);
            chk("R2 sdram/usb /2", {sdram_o, usb_o}, ((k % 2) == 0) ? 2'b11 : 2'b00);
            chk("R3 v66 /3", v66_o, (k % 3) == 0);
            chk("R4 pci /6", pci_o, (k % 6) < 3);
            chk("R4 ref low phase", ref_o, 1'b0);
            if (strap_hi) chk("R8 apic full rate", apic_o, (k % 6) < 3);
            else          chk("R8 apic half rate", apic_o, (k % 12) < 6);
            if (k == 0) chk("R9 common rise", {cpu_o, v66_o, pci_o, apic_o}, 4'hF);
            @(posedge clk); #2;
            chk("R4 ref equals test clock", ref_o, 1'b1);
            @(negedge clk);
        end
        sel = 2'b10;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R10 reset state, window still open
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10 ref_oe after reset", ref_oe, 1'b0);
        chk("R10 ref_o after reset", ref_o, 1'b0);
        chk("R10 other enables", oes(), 7'b1111110);
        p33 = 1'b1; #1;
        chk("R10 strap default high, apic copies pci", apic_o, 1'b1);
        @(negedge clk); p33 = 1'b0;

        // R6 window count
        for (int i = 0; i < TICKS - 1; i++) pulse_tick();
        #1; chk("R6 ref_oe before final tick", ref_oe, 1'b0);
        pulse_tick();
        #1; chk("R6 ref_oe after final tick", ref_oe, 1'b1);

        // Vector table: R1 and R5
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            sel = VEC[v][20:19];
            {p66, p100, p33, p48, osc} = VEC[v][18:14];
            #1;
            chk(VEC[v][20:19] == 2'b00 ? "R1 hiz outputs" : "R5 routing", outs(), VEC[v][13:7]);
            chk(VEC[v][20:19] == 2'b00 ? "R1 hiz enables" : "R6 enables", oes(), VEC[v][6:0]);
        end
        {p66, p100, p33, p48, osc} = 5'b0;

        // Test mode with high strap: R2 R3 R4 R8 R9
        run_test_mode(1'b1);

        // Strap low captured on the final tick only: R7
        do_reset();
        pad = 1'b1;
        for (int i = 0; i < TICKS - 1; i++) pulse_tick();
        @(negedge clk); pad = 1'b0;
        pulse_tick();
        pad = 1'b1;
        #1; chk("R6 ref_oe on after window", ref_oe, 1'b1);
        run_test_mode(1'b0);

        // Normal-mode half-rate APIC, pad toggling has no effect: R7 R8
        @(negedge clk); sel = 2'b10; p33 = 1'b0;
        @(negedge clk);
        begin
            int rises = 0;
            for (int j = 0; j < 16; j++) begin
                @(negedge clk);
                p33 = ~p33;
                pad = ~pad;
                if (p33) rises++;
                #1;
                chk("R8 R7 apic half of pci", apic_o, (rises % 2) == 1);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule